// File: doc/BRIEF.md
# Bus Transfer Error Timeout Monitor

This block watches a synchronous bus with a single master and ends any cycle that no slave acknowledges in time. Each start strobe arms a clock counter. If no acknowledge arrives before the counter reaches a programmable limit, the block pulls a shared, active-low error line for exactly one clock. Because the error is released at the next edge, a new cycle that starts right after it is not hit by a stale error.

The block also combines a set of external error requests into the same error output. Each request is registered before it is merged. The block reads back the resolved error line, which is the wired-OR of its own driver and any other open-drain sources. When it sees that line low, it treats the current cycle as ended by someone else and stops counting. The open-drain driver is modelled as a drive value plus an output enable, and the board-level wiring resolves them.

Top module: `bus_err_timeout_mon`

## Requirements
- R1: After a synchronous reset, `err_oe` is 0 and `err_drive_n` is 1.
- R2: Let edge E0 be the rising edge that samples `xfer_start` high, and let L = `limit_cfg` with L > 0. If `xfer_ack` is low and the resolved line is high at edges E1..EL, then `err_oe` is 1 in the clock that follows edge EL.
- R3: If `xfer_ack` is sampled high at any edge from E1 to EL, no timeout error is produced for that cycle. This includes edge EL itself, the edge at which the limit would expire.
- R4: A timeout error lasts exactly one clock. The output is released at the next edge, before the second edge after it was first sampled.
- R5: When `limit_cfg` is 0, the timeout is disabled and no timeout error is ever produced.
- R6: A start strobe that arrives while a cycle is still being counted restarts the count from zero. The limit is then measured from the new strobe.
- R7: If any bit of `ext_err_req` is sampled high at an edge, `err_oe` is 1 in the following clock. The output stays high while any request stays high and drops one edge after all requests are low.
- R8: If the resolved line `err_line_n` is sampled low while a cycle is being counted, that cycle ends and no timeout follows from it.
- R9: Open-drain model: whenever `err_oe` is 1, `err_drive_n` is 0. Whenever `err_oe` is 0, `err_drive_n` is 1.
- R10: An acknowledge with no cycle in progress, or a run of clocks with no start strobe, produces no timeout error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xfer_start | input | 1 | Transfer start strobe, active high, one clock per cycle |
| xfer_ack | input | 1 | Transfer acknowledge from a slave, active high |
| limit_cfg | input | CNT_W | Timeout limit in clocks after the start; 0 disables the timeout |
| ext_err_req | input | N_EXT | External error requests, active high, merged into the output |
| err_line_n | input | 1 | Resolved wired-OR error line, active low, read back |
| err_drive_n | output | 1 | Drive value of the open-drain error pin, 0 when pulling low |
| err_oe | output | 1 | Output enable of the open-drain error pin |

## Verification
Some properties are checked by assertions on every clock:
- the timeout pulse is never longer than one clock;
- an acknowledge during a counted cycle suppresses the pulse at the next edge;
- no pulse appears while idle or with a zero limit;
- a registered external request always raises the enable;
- the drive value always agrees with the enable.

Other behaviour depends on exact edge counts, so only the bench scenarios can show it:
- the error lands exactly L clocks after the start;
- an acknowledge on the expiry edge itself wins;
- a second strobe rearms the count;
- another open-drain source pulling the line low cancels a pending timeout.

// File: rtl/bet_pkg.sv
package bet_pkg;
  typedef enum logic {
    MON_IDLE  = 1'b0,
    MON_ARMED = 1'b1
  } mon_state_t;
endpackage

// File: rtl/bet_timer.sv
module bet_timer
  import bet_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_start,
  input  logic             xfer_ack,
  input  logic             line_low,
  input  logic [CNT_W-1:0] limit_cfg,
  output logic             to_pulse,
  output logic             armed
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  mon_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             expire;

  assign cnt_nx = cnt_q + CNT_ONE;
  assign expire = (limit_cfg != '0) && (cnt_nx == limit_cfg);
  assign armed  = (st_q == MON_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= MON_IDLE;
      cnt_q    <= '0;
      to_pulse <= 1'b0;
    end else begin
      to_pulse <= 1'b0;
      if (xfer_start) begin
        st_q  <= MON_ARMED;
        cnt_q <= '0;
      end else if (st_q == MON_ARMED) begin
        if (xfer_ack || line_low) begin
          st_q <= MON_IDLE;
        end else if (expire) begin
          st_q     <= MON_IDLE;
          to_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  // R4: a timeout pulse never lasts two clocks
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    to_pulse |=> !to_pulse);
  // R3: an acknowledge in a counted cycle blocks the pulse
  assert_ack_blocks_timeout_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && xfer_ack && !xfer_start) |=> !to_pulse);
  // R10: no pulse from the idle state
  assert_idle_no_timeout_R10: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !to_pulse);
  // R5: a zero limit never times out
  assert_zero_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (limit_cfg == '0) |=> !to_pulse);
  // R8: a low line ends the cycle without a pulse
  assert_line_ends_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && line_low && !xfer_start) |=> (!to_pulse && !armed));
endmodule

// File: rtl/bet_err_merge.sv
module bet_err_merge #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             to_pulse,
  input  logic [N_SRC-1:0] ext_req,
  output logic             err_oe,
  output logic             err_drive_n
);
  logic [N_SRC-1:0] ext_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) ext_q[i] <= 1'b0;
      else     ext_q[i] <= ext_req[i];
    end
  end

  assign err_oe      = to_pulse | (|ext_q);
  assign err_drive_n = ~err_oe;

  // R7: any sampled request raises the enable in the next clock
  assert_ext_sets_err_R7: assert property (@(posedge clk) disable iff (rst)
    (|ext_req) |=> err_oe);
  // R2: a timeout pulse from the counter reaches the pin
  assert_timeout_reaches_pin_R2: assert property (@(posedge clk) disable iff (rst)
    to_pulse |-> err_oe);
endmodule

// File: rtl/bus_err_timeout_mon.sv
module bus_err_timeout_mon #(
  parameter int CNT_W = 8,
  parameter int N_EXT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_start,
  input  logic             xfer_ack,
  input  logic [CNT_W-1:0] limit_cfg,
  input  logic [N_EXT-1:0] ext_err_req,
  input  logic             err_line_n,
  output logic             err_drive_n,
  output logic             err_oe
);
  logic to_pulse;
  logic armed;

  bet_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .xfer_ack   (xfer_ack),
    .line_low   (~err_line_n),
    .limit_cfg  (limit_cfg),
    .to_pulse   (to_pulse),
    .armed      (armed)
  );

  bet_err_merge #(.N_SRC(N_EXT)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .to_pulse    (to_pulse),
    .ext_req     (ext_err_req),
    .err_oe      (err_oe),
    .err_drive_n (err_drive_n)
  );

  // R9: the pin is pulled low exactly when enabled
  assert_od_drive_R9: assert property (@(posedge clk) disable iff (rst)
    err_oe |-> !err_drive_n);
  assert_od_release_R9: assert property (@(posedge clk) disable iff (rst)
    !err_oe |-> err_drive_n);
endmodule

// File: tb/tb_bus_err_timeout_mon.sv
module tb_bus_err_timeout_mon;
  localparam int CNT_W = 8;
  localparam int N_EXT = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             xfer_start = 1'b0;
  logic             xfer_ack = 1'b0;
  logic [CNT_W-1:0] limit_cfg = '0;
  logic [N_EXT-1:0] ext_err_req = '0;
  logic             other_pull = 1'b0;
  logic             err_line_n;
  logic             err_drive_n;
  logic             err_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    bit    exp_err;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // model state, built from the requirements
  bit m_busy = 0;
  int m_cnt = 0;
  bit m_err = 0;

  always #2 clk = ~clk;

  // wired-OR resolution of the open-drain line with another source
  assign err_line_n = ~((err_oe & ~err_drive_n) | other_pull);

  bus_err_timeout_mon #(.CNT_W(CNT_W), .N_EXT(N_EXT)) dut (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
    .limit_cfg(limit_cfg), .ext_err_req(ext_err_req), .err_line_n(err_line_n),
    .err_drive_n(err_drive_n), .err_oe(err_oe)
  );

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one clock of stimulus, pushes the expected enable after the edge
  task automatic step(input bit st, input bit ak, input bit [N_EXT-1:0] ex,
                      input bit pl, input string tag);
    bit line_low;
    bit to;
    @(negedge clk);
    xfer_start  = st;
    xfer_ack    = ak;
    ext_err_req = ex;
    other_pull  = pl;
    line_low = m_err | pl;
    to = 0;
    if (st) begin
      m_busy = 1; m_cnt = 0;
    end else if (m_busy) begin
      if (ak || line_low) m_busy = 0;
      else if (limit_cfg != 0 && m_cnt + 1 == int'(limit_cfg)) begin
        to = 1; m_busy = 0;
      end else m_cnt++;
    end
    m_err = to | (|ex);
    sb_q.push_back('{exp_err: m_err, tag: tag});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, tag);
  endtask

  // monitor: compares each result just after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(err_oe == e.exp_err, e.tag, err_oe, e.exp_err);
        check(err_drive_n == !err_oe, "R9", err_drive_n, !err_oe);
      end
    end
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(err_oe == 0, "R1", err_oe, 0);
    check(err_drive_n == 1, "R1", err_drive_n, 1);
    @(negedge clk);
    rst = 0;

    // R2 + R4: limit 4, no acknowledge -> one-clock error
    limit_cfg = 8'd4;
    step(1, 0, '0, 0, "R2");
    idle(6, "R2_R4");
    // R3: acknowledge before expiry
    step(1, 0, '0, 0, "R3");
    idle(2, "R3");
    step(0, 1, '0, 0, "R3");
    idle(4, "R3");
    // R3: acknowledge on the expiry edge wins
    step(1, 0, '0, 0, "R3");
    idle(3, "R3");
    step(0, 1, '0, 0, "R3");
    idle(3, "R3");
    // R5: zero limit
    limit_cfg = 8'd0;
    step(1, 0, '0, 0, "R5");
    idle(20, "R5");
    // R6: restart rearms the count
    limit_cfg = 8'd5;
    step(1, 0, '0, 0, "R6");
    idle(3, "R6");
    step(1, 0, '0, 0, "R6");
    idle(7, "R6");
    // R7: external requests held and released
    limit_cfg = 8'd0;
    step(0, 0, 2'b01, 0, "R7");
    step(0, 0, 2'b11, 0, "R7");
    step(0, 0, 2'b10, 0, "R7");
    idle(3, "R7");
    // R8: another source pulls the line during a counted cycle
    limit_cfg = 8'd6;
    step(1, 0, '0, 0, "R8");
    idle(2, "R8");
    step(0, 0, '0, 1, "R8");
    idle(8, "R8");
    // R10: acknowledge while idle
    limit_cfg = 8'd1;
    step(0, 1, '0, 0, "R10");
    idle(4, "R10");
    // R2: minimum limit of one clock
    step(1, 0, '0, 0, "R2");
    idle(3, "R2_R4");
    // R7 with timeout in flight
    limit_cfg = 8'd3;
    step(1, 0, '0, 0, "R7");
    step(0, 0, 2'b10, 0, "R7");
    idle(6, "R7");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule